// File: doc/BRIEF.md
# Table-access mailbox responder

This block answers table-read requests that software places in a mailbox. Software pushes a request object into a write mailbox one dword at a time and then pulses a start input. The block checks the request, takes the entry handle from it, looks that entry up in a built-in table of variable-length entries, and appends a response object to a read mailbox. Software then takes the response out one dword at a time.

Every response names the handle of the entry that follows the one just returned. After the last entry it names an end-of-table marker. Software can therefore walk the whole table by starting at handle 0 and feeding each returned handle into the next request. A request that is too short, or that names a handle outside the table, is dropped and gets no response.

Top module: `tam_responder`

## Requirements
- R1: After reset, busy and ready are 0 and rd_level is 0.
- R2: A dword is written to the write mailbox in each cycle where wr_valid is 1, at the next free slot. Slot 0 holds the vendor ID in bits 15:0 and the object type in bits 23:16. Slot 1 holds the length in dwords in bits 17:0. Slot 2 holds the request code in bits 7:0, the table type in bits 15:8 and the entry handle in bits 31:16. Writes beyond WMB_DEPTH dwords are ignored.
- R3: A request is dropped, with no response and no change to rd_level, when its length field is less than 3 or when fewer than 3 dwords were written. Any length field of 3 or more is accepted.
- R4: A request whose handle is equal to or greater than N_ENTRIES is dropped in the same way.
- R5: A go pulse while idle makes busy 1 from the next cycle. busy returns to 0 once the response is complete or the request is dropped, and the write mailbox is then empty.
- R6: Response dword 0 is {8'h00, OBJ_TYPE, VENDOR_ID}. The field above the object type is zero.
- R7: Response dword 1 holds the response length in dwords in bits 17:0, and the upper bits are zero. The length is ceil((12 + entry byte length) / 4).
- R8: Response dword 2 is {next, TABLE_TYPE, RSP_CODE}. next is the handle plus 1, or 16'hFFFF when the handle is N_ENTRIES-1.
- R9: The entry payload follows directly as dwords 3 and up, in stored order. Entry i is 1 + (7*i mod 4*MAX_ENT_DW) bytes long. Byte b of payload dword j is (16*i + 4*j + b + 48) mod 256 when 4*j+b is below that length, and 0 otherwise.
- R10: rd_level grows by the response length for each response. ready is 1 exactly when rd_level is nonzero. rd_data shows the oldest dword, and an rd_pop advances it and decrements rd_level. An rd_pop on an empty mailbox is ignored.
- R11: A walk from handle 0 that follows the returned next handles visits every entry once and ends at 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Append wr_data to the write mailbox |
| wr_data | input | 32 | Request dword |
| go | input | 1 | Start processing the request held in the write mailbox |
| rd_pop | input | 1 | Consume the oldest read-mailbox dword |
| rd_data | output | 32 | Oldest read-mailbox dword (zero when empty) |
| rd_level | output | $clog2(RMB_DEPTH+1) | Dwords held in the read mailbox |
| ready | output | 1 | Read mailbox holds data |
| busy | output | 1 | A request is being checked or answered |

## Verification
The bench walks the whole table from handle 0 and compares every header field and payload byte with values it computes from the length and content formulas. A design with a broken next-handle step would loop or stop early. A design with wrong rounding would cut off or pad the partial last dword of the 1-, 15- and 22-byte entries. The bench targets the drop boundaries: a length field of 2 against a length of exactly 3 and a large one, only two dwords written, and handles N_ENTRIES and 16'hFFFF. A wrong comparison there would give a spurious response or lose a valid one. It also queues two responses before draining, which catches a mailbox that overwrites instead of appending. It pops an empty mailbox, which would make the level wrap, and it overfills the write mailbox, which would corrupt the request.

// File: rtl/tam_pkg.sv
package tam_pkg;

   localparam int unsigned REQ_DW = 3;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_EMIT  = 2'd2
   } eng_state_t;

   // byte length of table entry i
   function automatic int unsigned ent_bytes(input int unsigned i, input int unsigned max_dw);
      return 1 + ((7 * i) % (4 * max_dw));
   endfunction

   // dword j of entry i, bytes past the entry length read as zero
   function automatic logic [31:0] ent_word(input int unsigned i, input int unsigned j,
                                            input int unsigned nbytes);
      logic [31:0] w;
      w = '0;
      for (int unsigned b = 0; b < 4; b++) begin
         if ((4 * j + b) < nbytes)
            w[8*b +: 8] = 8'((16 * i + 4 * j + b + 48) % 256);
      end
      return w;
   endfunction

endpackage

// File: rtl/tam_wr_mbox.sv
module tam_wr_mbox #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   input  logic [31:0]   wr_data,
   input  logic          clear,
   output logic [17:0]   len_fld,
   output logic [15:0]   handle,
   output logic [CW-1:0] count
);

   logic [31:0]   slot_q [DEPTH];
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int k = 0; k < DEPTH; k++) slot_q[k] <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (wr_valid && (cnt_q < CW'(DEPTH))) begin
         slot_q[cnt_q[$clog2(DEPTH)-1:0]] <= wr_data;
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign len_fld = slot_q[1][17:0];
   assign handle  = slot_q[2][31:16];
   assign count   = cnt_q;

endmodule

// File: rtl/tam_entry_rom.sv
module tam_entry_rom #(
   parameter int unsigned N_ENTRIES  = 4,
   parameter int unsigned MAX_ENT_DW = 6,
   localparam int unsigned IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
   localparam int unsigned WW = (MAX_ENT_DW > 1) ? $clog2(MAX_ENT_DW) : 1,
   localparam int unsigned BW = $clog2(4 * MAX_ENT_DW + 1)
) (
   input  logic [IW-1:0] idx,
   input  logic [WW-1:0] word,
   output logic [31:0]   data,
   output logic [BW-1:0] nbytes
);

   logic [BW-1:0] len_tab  [N_ENTRIES];
   logic [31:0]   word_tab [N_ENTRIES][MAX_ENT_DW];

   for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
      assign len_tab[g] = BW'(tam_pkg::ent_bytes(g, MAX_ENT_DW));
      for (genvar k = 0; k < MAX_ENT_DW; k++) begin : g_word
         assign word_tab[g][k] =
            tam_pkg::ent_word(g, k, tam_pkg::ent_bytes(g, MAX_ENT_DW));
      end
   end

   always_comb begin
      data   = '0;
      nbytes = '0;
      if (32'(idx) < N_ENTRIES) begin
         nbytes = len_tab[idx];
         if (32'(word) < MAX_ENT_DW) data = word_tab[idx][word];
      end
   end

endmodule

// File: rtl/tam_rd_mbox.sv
module tam_rd_mbox #(
   parameter int unsigned DEPTH      = 32,
   parameter bit          MASK_EMPTY = 1'b1,
   localparam int unsigned PW = $clog2(DEPTH),
   localparam int unsigned LW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [31:0]   push_data,
   input  logic          pop,
   output logic [31:0]   head,
   output logic [LW-1:0] level,
   output logic          ready,
   output logic [LW-1:0] space
);

   logic [31:0]   mem_q [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [LW-1:0] lvl_q;
   logic          do_push, do_pop;

   assign do_push = push && (lvl_q < LW'(DEPTH));
   assign do_pop  = pop && (lvl_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         lvl_q <= '0;
         for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
      end else begin
         if (do_push) begin
            mem_q[wp_q] <= push_data;
            wp_q        <= wp_q + PW'(1);
         end
         if (do_pop) rp_q <= rp_q + PW'(1);
         case ({do_push, do_pop})
            2'b10:   lvl_q <= lvl_q + LW'(1);
            2'b01:   lvl_q <= lvl_q - LW'(1);
            default: lvl_q <= lvl_q;
         endcase
      end
   end

   assign level = lvl_q;
   assign ready = (lvl_q != '0);
   assign space = LW'(DEPTH) - lvl_q;

   if (MASK_EMPTY) begin : g_mask
      assign head = ready ? mem_q[rp_q] : '0;
   end else begin : g_raw
      assign head = mem_q[rp_q];
   end

endmodule

// File: rtl/tam_rsp_engine.sv
module tam_rsp_engine #(
   parameter logic [15:0] VENDOR_ID  = 16'h1E98,
   parameter logic [7:0]  OBJ_TYPE   = 8'h02,
   parameter logic [7:0]  RSP_CODE   = 8'h00,
   parameter logic [7:0]  TABLE_TYPE = 8'h00,
   parameter int unsigned N_ENTRIES  = 4,
   parameter int unsigned MAX_ENT_DW = 6,
   parameter int unsigned WMB_DEPTH  = 8,
   parameter int unsigned RMB_DEPTH  = 32,
   localparam int unsigned IW  = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
   localparam int unsigned WW  = (MAX_ENT_DW > 1) ? $clog2(MAX_ENT_DW) : 1,
   localparam int unsigned BW  = $clog2(4 * MAX_ENT_DW + 1),
   localparam int unsigned RW  = $clog2(MAX_ENT_DW + 4),
   localparam int unsigned WCW = $clog2(WMB_DEPTH + 1),
   localparam int unsigned LW  = $clog2(RMB_DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go,
   input  logic [17:0]    wmb_len,
   input  logic [15:0]    wmb_handle,
   input  logic [WCW-1:0] wmb_count,
   output logic           wmb_clear,
   output logic [IW-1:0]  rom_idx,
   output logic [WW-1:0]  rom_word,
   input  logic [31:0]    rom_data,
   input  logic [BW-1:0]  rom_bytes,
   input  logic [LW-1:0]  rmb_space,
   output logic           push,
   output logic [31:0]    push_data,
   output logic           busy
);
   import tam_pkg::*;

   eng_state_t     st_q;
   logic [15:0]    hnd_q;
   logic [RW-1:0]  rlen_q, pos_q;
   logic           req_ok, last_ent, final_dw;
   logic [15:0]    next_hnd;
   logic [RW-1:0]  rsp_len, pay_pos;

   assign req_ok = (wmb_count >= WCW'(REQ_DW)) && (wmb_len >= 18'(REQ_DW))
                   && (hnd_q < 16'(N_ENTRIES));
   assign rsp_len  = RW'(REQ_DW + ((32'(rom_bytes) + 32'd3) >> 2));
   assign last_ent = (hnd_q == 16'(N_ENTRIES - 1));
   assign next_hnd = last_ent ? 16'hFFFF : (hnd_q + 16'd1);
   assign pay_pos  = pos_q - RW'(REQ_DW);

   assign rom_idx  = hnd_q[IW-1:0];
   assign rom_word = (pos_q >= RW'(REQ_DW)) ? pay_pos[WW-1:0] : '0;

   assign push     = (st_q == ST_EMIT) && (rmb_space != '0);
   assign final_dw = (pos_q == rlen_q - RW'(1));
   assign busy     = (st_q != ST_IDLE);
   assign wmb_clear = ((st_q == ST_CHECK) && !req_ok) || (push && final_dw);

   always_comb begin
      case (pos_q)
         RW'(0):  push_data = {8'h00, OBJ_TYPE, VENDOR_ID};
         RW'(1):  push_data = {{(32-RW){1'b0}}, rlen_q};
         RW'(2):  push_data = {next_hnd, TABLE_TYPE, RSP_CODE};
         default: push_data = rom_data;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         hnd_q  <= '0;
         rlen_q <= '0;
         pos_q  <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (go) begin
               hnd_q <= wmb_handle;
               st_q  <= ST_CHECK;
            end
            ST_CHECK: begin
               if (req_ok) begin
                  rlen_q <= rsp_len;
                  pos_q  <= '0;
                  st_q   <= ST_EMIT;
               end else begin
                  st_q <= ST_IDLE;
               end
            end
            ST_EMIT: if (push) begin
               pos_q <= pos_q + RW'(1);
               if (final_dw) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/tam_responder.sv
module tam_responder #(
   parameter logic [15:0] VENDOR_ID  = 16'h1E98,
   parameter logic [7:0]  OBJ_TYPE   = 8'h02,
   parameter logic [7:0]  RSP_CODE   = 8'h00,
   parameter logic [7:0]  TABLE_TYPE = 8'h00,
   parameter int unsigned N_ENTRIES  = 4,
   parameter int unsigned MAX_ENT_DW = 6,
   parameter int unsigned WMB_DEPTH  = 8,
   parameter int unsigned RMB_DEPTH  = 32,
   parameter bit          MASK_EMPTY = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_valid,
   input  logic [31:0]                    wr_data,
   input  logic                           go,
   input  logic                           rd_pop,
   output logic [31:0]                    rd_data,
   output logic [$clog2(RMB_DEPTH+1)-1:0] rd_level,
   output logic                           ready,
   output logic                           busy
);
   localparam int unsigned IW  = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
   localparam int unsigned WW  = (MAX_ENT_DW > 1) ? $clog2(MAX_ENT_DW) : 1;
   localparam int unsigned BW  = $clog2(4 * MAX_ENT_DW + 1);
   localparam int unsigned WCW = $clog2(WMB_DEPTH + 1);
   localparam int unsigned LW  = $clog2(RMB_DEPTH + 1);

   initial begin
      if (WMB_DEPTH < tam_pkg::REQ_DW) $error("WMB_DEPTH must hold a whole request");
      if (RMB_DEPTH < MAX_ENT_DW + tam_pkg::REQ_DW) $error("RMB_DEPTH must hold the largest response");
      if ((RMB_DEPTH & (RMB_DEPTH - 1)) != 0) $error("RMB_DEPTH must be a power of two");
      if ((WMB_DEPTH & (WMB_DEPTH - 1)) != 0) $error("WMB_DEPTH must be a power of two");
      if (N_ENTRIES < 1 || N_ENTRIES > 65535) $error("N_ENTRIES out of range");
      if (MAX_ENT_DW < 1) $error("MAX_ENT_DW must be positive");
   end

   logic [17:0]    wmb_len;
   logic [15:0]    wmb_handle;
   logic [WCW-1:0] wmb_count;
   logic           wmb_clear;
   logic [IW-1:0]  rom_idx;
   logic [WW-1:0]  rom_word;
   logic [31:0]    rom_data;
   logic [BW-1:0]  rom_bytes;
   logic [LW-1:0]  rmb_space;
   logic           push;
   logic [31:0]    push_data;

   tam_wr_mbox #(.DEPTH(WMB_DEPTH)) u_wr_mbox (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .clear(wmb_clear), .len_fld(wmb_len), .handle(wmb_handle), .count(wmb_count)
   );

   tam_entry_rom #(.N_ENTRIES(N_ENTRIES), .MAX_ENT_DW(MAX_ENT_DW)) u_rom (
      .idx(rom_idx), .word(rom_word), .data(rom_data), .nbytes(rom_bytes)
   );

   tam_rsp_engine #(
      .VENDOR_ID(VENDOR_ID), .OBJ_TYPE(OBJ_TYPE), .RSP_CODE(RSP_CODE),
      .TABLE_TYPE(TABLE_TYPE), .N_ENTRIES(N_ENTRIES), .MAX_ENT_DW(MAX_ENT_DW),
      .WMB_DEPTH(WMB_DEPTH), .RMB_DEPTH(RMB_DEPTH)
   ) u_engine (
      .clk(clk), .rst_n(rst_n), .go(go),
      .wmb_len(wmb_len), .wmb_handle(wmb_handle), .wmb_count(wmb_count),
      .wmb_clear(wmb_clear), .rom_idx(rom_idx), .rom_word(rom_word),
      .rom_data(rom_data), .rom_bytes(rom_bytes), .rmb_space(rmb_space),
      .push(push), .push_data(push_data), .busy(busy)
   );

   tam_rd_mbox #(.DEPTH(RMB_DEPTH), .MASK_EMPTY(MASK_EMPTY)) u_rd_mbox (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
      .pop(rd_pop), .head(rd_data), .level(rd_level), .ready(ready),
      .space(rmb_space)
   );

endmodule

// File: rtl/tam_responder_chk.sv
module tam_responder_chk #(
   parameter int unsigned RMB_DEPTH = 32,
   localparam int unsigned LW = $clog2(RMB_DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          go,
   input logic          rd_pop,
   input logic [LW-1:0] rd_level,
   input logic          ready,
   input logic          busy
);

   // R5: an accepted start makes the block busy on the next cycle
   a_r5_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !busy) |=> busy);

   // R10: with no request in flight and no pop, the level holds
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !rd_pop) |=> $stable(rd_level));

   // R10: a pop of a non-empty mailbox while idle drops the level by one
   a_r10_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && rd_pop && ready) |=> (rd_level == $past(rd_level) - 1'b1));

   // R10: a pop of an empty mailbox leaves it empty
   a_r10_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && rd_pop && !ready) |=> (rd_level == '0));

   // R10: without a pop the level never falls and grows by at most one dword
   a_r10_growth: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_pop |=> ((rd_level == $past(rd_level)) || (rd_level == $past(rd_level) + 1'b1)));

   // R10: level stays within the mailbox depth
   a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rd_level <= LW'(RMB_DEPTH));

endmodule

bind tam_responder tam_responder_chk #(.RMB_DEPTH(RMB_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .go(go), .rd_pop(rd_pop),
   .rd_level(rd_level), .ready(ready), .busy(busy)
);

// File: tb/tam_responder_bench.sv
module tam_responder_bench;
   localparam int unsigned N  = 4;
   localparam int unsigned MD = 6;
   localparam int unsigned LW = $clog2(32 + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [31:0]   wr_data = '0;
   logic          go = 1'b0;
   logic          rd_pop = 1'b0;
   logic [31:0]   rd_data;
   logic [LW-1:0] rd_level;
   logic          ready;
   logic          busy;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   tam_responder u_tam_responder (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .go(go), .rd_pop(rd_pop), .rd_data(rd_data), .rd_level(rd_level),
      .ready(ready), .busy(busy)
   );

   function automatic int unsigned exp_bytes(input int unsigned i);
      return 1 + ((7 * i) % (4 * MD));
   endfunction

   function automatic logic [31:0] exp_word(input int unsigned i, input int unsigned j);
      logic [31:0] w = '0;
      for (int unsigned b = 0; b < 4; b++)
         if (4 * j + b < exp_bytes(i)) w[8*b +: 8] = 8'((16 * i + 4 * j + b + 48) % 256);
      return w;
   endfunction

   function automatic int unsigned exp_len(input int unsigned i);
      return (12 + exp_bytes(i) + 3) / 4;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(input logic [31:0] d);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 200 && busy; k++) @(negedge clk);
   endtask

   task automatic pulse_go();
      @(negedge clk);
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
   endtask

   task automatic send_req(input logic [17:0] len, input logic [15:0] h, input int nwr);
      logic [31:0] w [3];
      w[0] = {8'h00, 8'h02, 16'h1E98};
      w[1] = {14'b0, len};
      w[2] = {h, 8'h00, 8'h00};
      for (int k = 0; k < nwr; k++) put(w[k]);
      pulse_go();
      wait_idle();
   endtask

   task automatic pop(output logic [31:0] d);
      @(negedge clk);
      d = rd_data;
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
   endtask

   task automatic check_rsp(input int unsigned h, output logic [15:0] nxt);
      logic [31:0] d;
      pop(d);
      chk("R6 header dword", d, {8'h00, 8'h02, 16'h1E98});
      pop(d);
      chk("R7 length dword", d, 32'(exp_len(h)));
      pop(d);
      chk("R8 response dword", d, {((h == N - 1) ? 16'hFFFF : 16'(h + 1)), 8'h00, 8'h00});
      nxt = d[31:16];
      for (int unsigned j = 0; j < exp_len(h) - 3; j++) begin
         pop(d);
         chk("R9 payload dword", d, exp_word(h, j));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] h;
      logic [15:0] nxt;
      logic [31:0] d;
      int visited;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", 32'(busy), 32'd0);
      chk("R1 ready", 32'(ready), 32'd0);
      chk("R1 level", 32'(rd_level), 32'd0);

      // R11 full walk
      h = 16'd0;
      visited = 0;
      while (h != 16'hFFFF && visited < 10) begin
         send_req(18'd3, h, 3);
         chk("R10 level after response", 32'(rd_level), 32'(exp_len(h)));
         chk("R10 ready with data", 32'(ready), 32'd1);
         check_rsp(h, nxt);
         chk("R10 ready after drain", 32'(ready), 32'd0);
         h = nxt;
         visited++;
      end
      chk("R11 entries visited", 32'(visited), 32'(N));
      chk("R11 end marker", 32'(h), 32'hFFFF);

      // R3 short length field
      send_req(18'd2, 16'd0, 3);
      chk("R3 short length dropped", 32'(rd_level), 32'd0);
      // R3 too few dwords written
      send_req(18'd3, 16'd1, 2);
      chk("R3 two dwords dropped", 32'(rd_level), 32'd0);
      // R3 large length field accepted
      send_req(18'd200, 16'd2, 3);
      chk("R3 large length accepted", 32'(rd_level), 32'(exp_len(2)));
      check_rsp(2, nxt);

      // R4 handle out of range
      send_req(18'd3, 16'(N), 3);
      chk("R4 handle N dropped", 32'(rd_level), 32'd0);
      send_req(18'd3, 16'hFFFF, 3);
      chk("R4 end marker dropped", 32'(rd_level), 32'd0);

      // R5 busy rises after go, falls when done
      put({8'h00, 8'h02, 16'h1E98});
      put(32'd3);
      put({16'd0, 16'h0000});
      pulse_go();
      chk("R5 busy after go", 32'(busy), 32'd1);
      wait_idle();
      chk("R5 busy cleared", 32'(busy), 32'd0);
      check_rsp(0, nxt);

      // R10 two responses queued back to back
      send_req(18'd3, 16'd1, 3);
      send_req(18'd3, 16'd3, 3);
      chk("R10 level accumulates", 32'(rd_level), 32'(exp_len(1) + exp_len(3)));
      check_rsp(1, nxt);
      check_rsp(3, nxt);
      chk("R8 last entry marker", 32'(nxt), 32'hFFFF);

      // R2 overfilled write mailbox
      put({8'h00, 8'h02, 16'h1E98});
      put(32'd3);
      put({16'd2, 16'h0000});
      for (int k = 0; k < 7; k++) put(32'hDEAD_0000 | 32'(k));
      pulse_go();
      wait_idle();
      chk("R2 overfill response level", 32'(rd_level), 32'(exp_len(2)));
      check_rsp(2, nxt);

      // R10 pop on empty ignored
      pop(d);
      @(negedge clk);
      chk("R10 pop empty level", 32'(rd_level), 32'd0);
      chk("R10 pop empty ready", 32'(ready), 32'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule